// File: doc/BRIEF.md
# Rename map checkpoint unit

This block tracks which physical register currently holds each architectural register, and which physical registers are free to be handed out. Every renamed instruction reads the physical tags of its two sources from the alias table. An instruction that writes a register takes a fresh tag from the head of a circular free list. It also receives the tag its destination held before, so the commit stage can return that tag later.

Each renamed branch saves a snapshot in a small FIFO of checkpoints. The snapshot holds the alias table and the free-list head pointer, taken after the branch's own rename. When a branch resolves correctly as taken, the oldest snapshot is thrown away. When a branch is mispredicted, the table and the head pointer are reloaded from the oldest snapshot and the whole FIFO is emptied. The free-list tail is not part of the snapshot, so tags returned by commits while the branch was in flight stay free. A one-cycle flush pulse tells the fetch and decode queues to drop their contents.

Rename stalls when the instruction needs a tag and none is free, or when it is a branch and the checkpoint FIFO is full.

Top module: `rename_ckpt_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, so `free_cnt_o` equals NUM_PHYS-NUM_ARCH. `ckpt_cnt_o` is 0 and `flush_o` is low.
- R2: `ren_src_a_tag_o`, `ren_src_b_tag_o` and `ren_prev_tag_o` show the current mapping of `ren_src_a_i`, `ren_src_b_i` and `ren_dst_i` in the same cycle. A source equal to the destination of the same instruction still reads the old mapping.
- R3: A rename accepted with `ren_dst_en_i` high receives the free-list head tag on `ren_dst_tag_o`. From the next cycle the destination maps to that tag, and `free_cnt_o` drops by one.
- R4: `ren_ready_o` is low when `ren_dst_en_i` is high and the free list is empty. A stalled rename changes no state. A rename without a destination is not held back by an empty free list.
- R5: A commit with `cmt_valid_i` high appends `cmt_tag_i` to the tail of the free list. Tags are handed out again in the order in which they entered the list.
- R6: An accepted rename with `ren_branch_i` high pushes one checkpoint. `ren_ready_o` is low for a branch while `ckpt_cnt_o` equals NUM_CKPT.
- R7: A resolve with `res_valid_i` high, `res_mispredict_i` low and `res_taken_i` high drops the oldest checkpoint, if one exists. A correct not-taken resolve leaves the checkpoints unchanged.
- R8: A mispredict (`res_valid_i` and `res_mispredict_i` both high) with at least one checkpoint restores the alias table and the free-list head from the oldest checkpoint and empties the FIFO. Tags freed by commits since then stay free. With no checkpoint, the table and the free list are unchanged.
- R9: `ren_ready_o` is low in every cycle that carries a mispredict.
- R10: `flush_o` is high for exactly the one cycle after each mispredict.
- R11: No physical tag is handed out twice without being freed, or recovered by a restore, in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| ren_branch_i | input | 1 | Request is a branch and needs a checkpoint |
| ren_dst_en_i | input | 1 | Request writes a destination register |
| ren_src_a_i | input | $clog2(NUM_ARCH) | First source architectural register |
| ren_src_b_i | input | $clog2(NUM_ARCH) | Second source architectural register |
| ren_dst_i | input | $clog2(NUM_ARCH) | Destination architectural register |
| ren_ready_o | output | 1 | Rename is accepted this cycle |
| ren_src_a_tag_o | output | $clog2(NUM_PHYS) | Physical tag of first source |
| ren_src_b_tag_o | output | $clog2(NUM_PHYS) | Physical tag of second source |
| ren_dst_tag_o | output | $clog2(NUM_PHYS) | Newly allocated destination tag |
| ren_prev_tag_o | output | $clog2(NUM_PHYS) | Tag the destination held before |
| res_valid_i | input | 1 | Branch resolution event |
| res_taken_i | input | 1 | Resolved branch was taken |
| res_mispredict_i | input | 1 | Resolved branch was mispredicted |
| cmt_valid_i | input | 1 | Commit returns a tag |
| cmt_tag_i | input | $clog2(NUM_PHYS) | Tag to return to the free list |
| flush_o | output | 1 | Clear fetch and decode queues |
| free_cnt_o | output | $clog2(NUM_PHYS)+1 | Number of free tags |
| ckpt_cnt_o | output | $clog2(NUM_CKPT+1) | Number of live checkpoints |

## Verification
The assertions check the following on every cycle:
- no allocation ever happens from an empty free list;
- the free count stays within its bound and grows by one for a lone commit;
- a checkpoint is never pushed into a full FIFO, and a clear always leaves it empty;
- an accepted destination write lands in the table;
- a correct taken resolve removes exactly one checkpoint;
- `flush_o` follows each mispredict by one cycle.

Some behaviour only the directed scenarios show:
- allocation and reuse order across commits;
- the content of a restored table;
- keeping commit frees across a restore;
- the no-effect cases (not-taken resolve, resolves with no checkpoint);
- that no tag is ever live twice.

// File: rtl/rmc_pkg.sv
`timescale 1ns/1ps
package rmc_pkg;
  typedef enum logic [2:0] {
    CK_IDLE,
    CK_PUSH,
    CK_POP,
    CK_SWAP,   // push newest and drop oldest in one cycle
    CK_CLEAR
  } ck_op_e;
endpackage

// File: rtl/rmc_map_table.sv
`timescale 1ns/1ps
module rmc_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int PW       = 4,
  localparam int AW      = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
  localparam int MW      = NUM_ARCH * PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_tag_i,
  input  logic          restore_i,
  input  logic [MW-1:0] restore_map_i,
  input  logic [AW-1:0] rd_a_idx_i,
  input  logic [AW-1:0] rd_b_idx_i,
  input  logic [AW-1:0] rd_d_idx_i,
  output logic [PW-1:0] rd_a_tag_o,
  output logic [PW-1:0] rd_b_tag_o,
  output logic [PW-1:0] rd_d_tag_o,
  output logic [MW-1:0] map_next_o
);
  logic [PW-1:0] map_q [NUM_ARCH];
  logic [PW-1:0] map_n [NUM_ARCH];

  always_comb begin
    map_n = map_q;
    if (wr_en_i) map_n[wr_idx_i] = wr_tag_i;
  end

  // reads see the table before this cycle's write
  assign rd_a_tag_o = map_q[rd_a_idx_i];
  assign rd_b_tag_o = map_q[rd_b_idx_i];
  assign rd_d_tag_o = map_q[rd_d_idx_i];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_flat
    assign map_next_o[g*PW +: PW] = map_n[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (restore_i) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= restore_map_i[i*PW +: PW];
    end else begin
      map_q <= map_n;
    end
  end

  assert_map_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !restore_i) |=> map_q[$past(wr_idx_i)] == $past(wr_tag_i));

  assert_map_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> map_q[0] == $past(restore_map_i[PW-1:0]));
endmodule

// File: rtl/rmc_free_list.sv
`timescale 1ns/1ps
// NUM_PHYS must be a power of two: pointers wrap through their extra bit.
module rmc_free_list #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int FPW     = PW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alloc_i,
  input  logic           free_i,
  input  logic [PW-1:0]  free_tag_i,
  input  logic           restore_i,
  input  logic [FPW-1:0] restore_head_i,
  output logic [PW-1:0]  head_tag_o,
  output logic [FPW-1:0] head_after_o,
  output logic [FPW-1:0] count_o
);
  logic [PW-1:0]  slot_q [NUM_PHYS];
  logic [FPW-1:0] head_q, tail_q;

  assign head_tag_o   = slot_q[head_q[PW-1:0]];
  assign head_after_o = head_q + FPW'(alloc_i);
  assign count_o      = tail_q - head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) slot_q[i] <= PW'(i);
      head_q <= FPW'(NUM_ARCH);
      tail_q <= FPW'(NUM_PHYS);
    end else begin
      if (free_i) begin
        slot_q[tail_q[PW-1:0]] <= free_tag_i;
        tail_q <= tail_q + FPW'(1);
      end
      head_q <= restore_i ? restore_head_i : head_after_o;
    end
  end

  assert_alloc_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> count_o != '0);

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FPW'(NUM_PHYS));

  assert_commit_grows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i && !alloc_i && !restore_i) |=> count_o == $past(count_o) + FPW'(1));
endmodule

// File: rtl/rmc_ckpt_fifo.sv
`timescale 1ns/1ps
module rmc_ckpt_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 37,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rmc_pkg::ck_op_e  op_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  import rmc_pkg::*;

  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [IW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  assign do_push   = (op_i == CK_PUSH) || (op_i == CK_SWAP);
  assign do_pop    = (op_i == CK_POP)  || (op_i == CK_SWAP);
  assign rd_data_o = ent_q[rd_q];
  assign full_o    = cnt_q == CW'(DEPTH);
  assign empty_o   = cnt_q == '0;
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (op_i == CK_CLEAR) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        ent_q[wr_q] <= wr_data_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (do_pop) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CK_PUSH) |-> !full_o);

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop |-> !empty_o);

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CK_CLEAR) |=> empty_o);
endmodule

// File: rtl/rename_ckpt_unit.sv
`timescale 1ns/1ps
module rename_ckpt_unit #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_CKPT = 2,
  localparam int AW      = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int FPW     = PW + 1,
  localparam int MW      = NUM_ARCH * PW,
  localparam int CKW     = MW + FPW,
  localparam int CW      = $clog2(NUM_CKPT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ren_valid_i,
  input  logic           ren_branch_i,
  input  logic           ren_dst_en_i,
  input  logic [AW-1:0]  ren_src_a_i,
  input  logic [AW-1:0]  ren_src_b_i,
  input  logic [AW-1:0]  ren_dst_i,
  output logic           ren_ready_o,
  output logic [PW-1:0]  ren_src_a_tag_o,
  output logic [PW-1:0]  ren_src_b_tag_o,
  output logic [PW-1:0]  ren_dst_tag_o,
  output logic [PW-1:0]  ren_prev_tag_o,
  input  logic           res_valid_i,
  input  logic           res_taken_i,
  input  logic           res_mispredict_i,
  input  logic           cmt_valid_i,
  input  logic [PW-1:0]  cmt_tag_i,
  output logic           flush_o,
  output logic [FPW-1:0] free_cnt_o,
  output logic [CW-1:0]  ckpt_cnt_o
);
  import rmc_pkg::*;

  logic           mispredict, drop, restore;
  logic           fire, alloc, push;
  logic           ck_full, ck_empty;
  ck_op_e         ck_op;
  logic [MW-1:0]  map_next;
  logic [FPW-1:0] head_after;
  logic [CKW-1:0] ck_rd;
  logic           flush_q;

  assign mispredict  = res_valid_i & res_mispredict_i;
  assign drop        = res_valid_i & ~res_mispredict_i & res_taken_i;
  assign restore     = mispredict & ~ck_empty;
  assign ren_ready_o = ~mispredict
                     & (~ren_dst_en_i | (free_cnt_o != '0))
                     & (~ren_branch_i | ~ck_full);
  assign fire        = ren_valid_i & ren_ready_o;
  assign alloc       = fire & ren_dst_en_i;
  assign push        = fire & ren_branch_i;

  always_comb begin
    ck_op = CK_IDLE;
    if (restore)                      ck_op = CK_CLEAR;
    else if (push && drop && !ck_empty) ck_op = CK_SWAP;
    else if (push)                    ck_op = CK_PUSH;
    else if (drop && !ck_empty)       ck_op = CK_POP;
  end

  rmc_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (alloc),
    .wr_idx_i      (ren_dst_i),
    .wr_tag_i      (ren_dst_tag_o),
    .restore_i     (restore),
    .restore_map_i (ck_rd[FPW +: MW]),
    .rd_a_idx_i    (ren_src_a_i),
    .rd_b_idx_i    (ren_src_b_i),
    .rd_d_idx_i    (ren_dst_i),
    .rd_a_tag_o    (ren_src_a_tag_o),
    .rd_b_tag_o    (ren_src_b_tag_o),
    .rd_d_tag_o    (ren_prev_tag_o),
    .map_next_o    (map_next)
  );

  rmc_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_i        (alloc),
    .free_i         (cmt_valid_i),
    .free_tag_i     (cmt_tag_i),
    .restore_i      (restore),
    .restore_head_i (ck_rd[FPW-1:0]),
    .head_tag_o     (ren_dst_tag_o),
    .head_after_o   (head_after),
    .count_o        (free_cnt_o)
  );

  // snapshot is taken after the branch's own rename
  rmc_ckpt_fifo #(.DEPTH(NUM_CKPT), .WIDTH(CKW)) u_ckpt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (ck_op),
    .wr_data_i ({map_next, head_after}),
    .rd_data_o (ck_rd),
    .full_o    (ck_full),
    .empty_o   (ck_empty),
    .count_o   (ckpt_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= mispredict;
  end
  assign flush_o = flush_q;

  assert_flush_after_mispredict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict |=> flush_o);

  assert_flush_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mispredict |=> !flush_o);

  assert_drop_oldest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !push && ckpt_cnt_o != '0) |=> ckpt_cnt_o == $past(ckpt_cnt_o) - CW'(1));

  assert_restore_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict |=> ckpt_cnt_o == '0);
endmodule

// File: tb/sim_rename_ckpt_unit.sv
`timescale 1ns/1ps
module sim_rename_ckpt_unit;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int NC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 0, ren_branch = 0, ren_dst_en = 0;
  logic [2:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
  logic       ren_ready;
  logic [3:0] src_a_tag, src_b_tag, dst_tag, prev_tag;
  logic       res_valid = 0, res_taken = 0, res_mis = 0;
  logic       cmt_valid = 0;
  logic [3:0] cmt_tag = 0;
  logic       flush;
  logic [4:0] free_cnt;
  logic [1:0] ckpt_cnt;

  always #10 clk = ~clk;

  rename_ckpt_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_valid), .ren_branch_i(ren_branch), .ren_dst_en_i(ren_dst_en),
    .ren_src_a_i(ren_src_a), .ren_src_b_i(ren_src_b), .ren_dst_i(ren_dst),
    .ren_ready_o(ren_ready), .ren_src_a_tag_o(src_a_tag), .ren_src_b_tag_o(src_b_tag),
    .ren_dst_tag_o(dst_tag), .ren_prev_tag_o(prev_tag),
    .res_valid_i(res_valid), .res_taken_i(res_taken), .res_mispredict_i(res_mis),
    .cmt_valid_i(cmt_valid), .cmt_tag_i(cmt_tag),
    .flush_o(flush), .free_cnt_o(free_cnt), .ckpt_cnt_o(ckpt_cnt)
  );

  int n_chk = 0, n_bad = 0;

  // reference model
  int m_map[NA];
  int m_fl[$];
  bit busy[NP];
  int old_q[$], old_seq[$];
  int al_tag[$], al_seq[$];
  int freed_log[$];
  int seq = 0;
  int ck_map[NC][NA];
  int ck_fl[NC][NP];
  int ck_fln[NC];
  int ck_log[NC];
  int ck_seq[NC];
  int ck_n = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_map(input string req);
    ren_valid = 0;
    for (int r = 0; r < NA; r++) begin
      ren_src_a = 3'(r);
      #1;
      chk($sformatf("%s map[%0d]", req, r), int'(src_a_tag), m_map[r]);
    end
  endtask

  task automatic do_rename(input bit br, input bit de, input int a, input int b, input int d);
    bit exp_rdy;
    int t;
    ren_valid = 1; ren_branch = br; ren_dst_en = de;
    ren_src_a = 3'(a); ren_src_b = 3'(b); ren_dst = 3'(d);
    #1;
    exp_rdy = !(de && m_fl.size() == 0) && !(br && ck_n == NC);
    chk("R4 R6 ready", int'(ren_ready), int'(exp_rdy));
    chk("R2 src a", int'(src_a_tag), m_map[a]);
    chk("R2 src b", int'(src_b_tag), m_map[b]);
    if (exp_rdy) begin
      if (de) begin
        t = int'(dst_tag);
        chk("R3 dst tag from head", t, m_fl[0]);
        chk("R2 prev tag", int'(prev_tag), m_map[d]);
        chk("R11 tag not live", int'(busy[t]), 0);
        busy[t] = 1;
        al_tag.push_back(t); al_seq.push_back(seq);
        old_q.push_back(m_map[d]); old_seq.push_back(seq);
        m_map[d] = m_fl[0];
        void'(m_fl.pop_front());
      end
      seq++;
      if (br) begin
        for (int i = 0; i < NA; i++) ck_map[ck_n][i] = m_map[i];
        for (int k = 0; k < m_fl.size(); k++) ck_fl[ck_n][k] = m_fl[k];
        ck_fln[ck_n] = m_fl.size();
        ck_log[ck_n] = freed_log.size();
        ck_seq[ck_n] = seq;
        ck_n++;
      end
    end
    step();
    ren_valid = 0; ren_branch = 0; ren_dst_en = 0;
    chk("R3 R4 free count", int'(free_cnt), m_fl.size());
    chk("R6 checkpoint count", int'(ckpt_cnt), ck_n);
  endtask

  task automatic commit_old();
    int t;
    t = old_q.pop_front();
    void'(old_seq.pop_front());
    cmt_valid = 1; cmt_tag = 4'(t);
    step();
    cmt_valid = 0;
    busy[t] = 0;
    m_fl.push_back(t);
    freed_log.push_back(t);
    chk("R5 free count after commit", int'(free_cnt), m_fl.size());
  endtask

  task automatic resolve(input bit taken, input bit mis);
    res_valid = 1; res_taken = taken; res_mis = mis;
    if (mis) begin
      ren_valid = 1; ren_branch = 0; ren_dst_en = 0;
      #1;
      chk("R9 rename blocked on mispredict", int'(ren_ready), 0);
    end
    if (mis && ck_n > 0) begin
      m_fl = {};
      for (int k = 0; k < ck_fln[0]; k++) m_fl.push_back(ck_fl[0][k]);
      for (int k = ck_log[0]; k < freed_log.size(); k++) m_fl.push_back(freed_log[k]);
      for (int i = 0; i < NA; i++) m_map[i] = ck_map[0][i];
      while (al_seq.size() > 0 && al_seq[al_seq.size()-1] >= ck_seq[0]) begin
        busy[al_tag[al_tag.size()-1]] = 0;
        void'(al_tag.pop_back()); void'(al_seq.pop_back());
      end
      while (old_seq.size() > 0 && old_seq[old_seq.size()-1] >= ck_seq[0]) begin
        void'(old_q.pop_back()); void'(old_seq.pop_back());
      end
      ck_n = 0;
    end else if (!mis && taken && ck_n > 0) begin
      for (int j = 0; j < ck_n - 1; j++) begin
        for (int i = 0; i < NA; i++) ck_map[j][i] = ck_map[j+1][i];
        for (int k = 0; k < NP; k++) ck_fl[j][k] = ck_fl[j+1][k];
        ck_fln[j] = ck_fln[j+1]; ck_log[j] = ck_log[j+1]; ck_seq[j] = ck_seq[j+1];
      end
      ck_n--;
    end
    step();
    res_valid = 0; res_taken = 0; res_mis = 0; ren_valid = 0;
    chk("R10 flush after resolve", int'(flush), int'(mis));
    chk("R7 R8 checkpoint count", int'(ckpt_cnt), ck_n);
    chk("R8 free count", int'(free_cnt), m_fl.size());
    if (mis) begin
      step();
      chk("R10 flush lasts one cycle", int'(flush), 0);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NA; i++) begin m_map[i] = i; busy[i] = 1; end
    for (int i = NA; i < NP; i++) begin m_fl.push_back(i); busy[i] = 0; end
    rst_n = 0;
    #35;
    rst_n = 1;
    step();
    check_map("R1");
    chk("R1 free count", int'(free_cnt), NP - NA);
    chk("R1 checkpoint count", int'(ckpt_cnt), 0);
    chk("R1 flush", int'(flush), 0);
    ren_branch = 1; ren_dst_en = 1;
    #1;
    chk("R1 ready", int'(ren_ready), 1);
    ren_branch = 0; ren_dst_en = 0;
  endtask

  task automatic t_basic();
    do_rename(0, 1, 2, 3, 1);
    do_rename(0, 1, 1, 1, 4);
    do_rename(0, 1, 1, 0, 1);   // source equals destination
    do_rename(0, 0, 1, 4, 0);
    check_map("R3");
  endtask

  task automatic t_free_order();
    commit_old();
    commit_old();
    for (int i = 0; i < 7; i++) do_rename(0, 1, i, 7 - i, (i + 2) % NA);
    chk("R4 list empty", int'(free_cnt), 0);
    do_rename(0, 1, 0, 1, 3);   // stalls
    do_rename(0, 0, 2, 3, 5);   // no destination, proceeds
    check_map("R4");
  endtask

  task automatic t_checkpoints();
    commit_old(); commit_old(); commit_old();
    do_rename(1, 0, 0, 1, 0);
    do_rename(0, 1, 2, 3, 2);
    commit_old();
    do_rename(1, 1, 4, 5, 5);
    do_rename(1, 0, 1, 2, 0);   // full, stalls
    resolve(0, 0);              // correct not-taken
    resolve(1, 0);              // correct taken
    do_rename(0, 1, 5, 6, 6);
    commit_old();
    resolve(0, 1);              // mispredict, restore
    check_map("R8");
    do_rename(0, 1, 6, 5, 7);
    do_rename(0, 1, 7, 6, 3);
    do_rename(0, 1, 3, 7, 0);
    resolve(1, 0);              // taken, no checkpoint
    resolve(0, 1);              // mispredict, no checkpoint
    check_map("R8");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_free_order();
    t_checkpoints();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule